// File: doc/BRIEF.md
# Pad Boundary-Scan Test Controller

This block is an IEEE 1149.1 style test access port that sits between the core's pad signals (drive value, drive enable, received value) and the physical bidirectional pads. Its boundary-scan chain has three cells per pad, so 32 pads give a 96-bit chain. An external tester steps the TAP state machine with TMS on the rising edge of TCK. It shifts instructions and data through TDI and TDO, samples the pads or takes them over.

Three operations are decoded. SAMPLE snapshots the pads and the core drive signals without disturbing normal operation. EXTEST drives every pad from a bank of update latches. BYPASS puts a single-bit path between TDI and TDO. A select input enables boundary scan as a whole. It is captured only while the chip reset is high, so moving it afterwards changes nothing until the next chip reset. While scan is disabled, the TAP is held in Test-Logic-Reset and the pads pass straight through.

Top module: `pad_scan_ctrl`

## Requirements
- R1: The TAP follows the 16-state 1149.1 state graph on rising TCK. The state machine reaches Test-Logic-Reset after five consecutive TMS-high cycles from any state, and also when `trst` is high at a rising edge.
- R2: The instruction register is 2 bits wide and shifts LSB first. Capture-IR loads 01, which shifts out as 1 then 0. Code 00 is EXTEST, 01 is SAMPLE and 11 is BYPASS. Code 10 behaves as BYPASS. In Test-Logic-Reset the instruction becomes BYPASS.
- R3: Under BYPASS the data path is one cell. It captures 0, and TDO then repeats TDI one shift later.
- R4: The boundary chain is 96 cells long and is entered from TDI at cell 95. Cell 0 sits nearest TDO. Pad p owns cell 3p (control), cell 3p+1 (output) and cell 3p+2 (input).
- R5: Under SAMPLE or EXTEST, Capture-DR loads each input cell from `pad_in`, each output cell from `core_out` and each control cell from `core_oe`.
- R6: The update latches take the output and control cells only in Update-DR under EXTEST. An Update-DR under SAMPLE leaves them unchanged. `trst` clears them to 0.
- R7: Under EXTEST, `pad_out`/`pad_oe` come from the update latches, and they stay steady while new data shifts. Under every other instruction they equal `core_out`/`core_oe`. `core_in` always equals `pad_in`.
- R8: TDO changes only on falling TCK. `tdo_oe` is high exactly while the TAP is in Shift-IR or Shift-DR.
- R9: `scan_sel` is captured while `sys_rst` is high. If it was captured low, the TAP stays in Test-Logic-Reset, `tdo_oe` stays low and the pads pass through. Changes of `scan_sel` outside `sys_rst` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst | input | 1 | Synchronous active-high TAP reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling TCK |
| tdo_oe | output | 1 | Drive enable for the TDO pad |
| sys_rst | input | 1 | Chip reset, active high; captures `scan_sel` |
| scan_sel | input | 1 | Boundary-scan enable, taken at chip reset |
| core_out | input | 32 | Core drive values, one per pad |
| core_oe | input | 32 | Core drive enables, one per pad |
| core_in | output | 32 | Pad values returned to the core |
| pad_in | input | 32 | Values received at the pads |
| pad_out | output | 32 | Values driven to the pads |
| pad_oe | output | 32 | Pad drive enables |

## Verification
Each serial result appears on TDO at the falling edge that follows the rising edge which moved the TAP into, or along, a shift state. The scoreboard queues the expected bits before a shift starts, and a monitor pops one bit each time it finds `tdo_oe` high, a few nanoseconds after each falling edge. Instruction and latch updates take effect on the rising edge that leaves Update-IR or Update-DR. Pad values are therefore checked just after that edge, and also in Exit1-DR before the update, to show that they hold while data shifts. TDO is also compared across each rising edge during a shift to confirm that it only moves on falling edges.

// File: rtl/pscan_pkg.sv
package pscan_pkg;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_st_e;

  typedef enum logic [1:0] {
    OP_EXTEST,
    OP_SAMPLE,
    OP_BYPASS
  } scan_op_e;

  localparam int IR_W          = 2;
  localparam int CELLS_PER_PAD = 3;

  // 00 external test, 01 sample, anything else single-cell bypass
  function automatic scan_op_e op_decode(input logic [IR_W-1:0] code);
    case (code)
      2'b00:   return OP_EXTEST;
      2'b01:   return OP_SAMPLE;
      default: return OP_BYPASS;
    endcase
  endfunction

endpackage

// File: rtl/pscan_tap_fsm.sv
module pscan_tap_fsm
  import pscan_pkg::*;
(
  input  logic    tck,
  input  logic    rst,
  input  logic    tms,
  output tap_st_e st
);

  tap_st_e nxt;

  always_comb begin
    nxt = st;
    case (st)
      TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  nxt = tms ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  nxt = tms ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SH_IR;
      TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_IDLE;
      default:   nxt = TS_RESET;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) st <= TS_RESET;
    else     st <= nxt;
  end

endmodule

// File: rtl/pscan_ir.sv
module pscan_ir
  import pscan_pkg::*;
#(
  parameter int W = IR_W
) (
  input  logic         tck,
  input  logic         rst,
  input  tap_st_e      st,
  input  logic         tdi,
  output logic [W-1:0] ir_sr,
  output scan_op_e     op
);

  localparam logic [W-1:0] CAP_PAT = W'(1);
  localparam logic [W-1:0] RST_PAT = '1;

  logic [W-1:0] ir_q;

  always_ff @(posedge tck) begin
    if (rst || st == TS_RESET) begin
      ir_q  <= RST_PAT;
      ir_sr <= '0;
    end else begin
      case (st)
        TS_CAP_IR: ir_sr <= CAP_PAT;
        TS_SH_IR:  ir_sr <= {tdi, ir_sr[W-1:1]};
        TS_UPD_IR: ir_q  <= ir_sr;
        default: ;
      endcase
    end
  end

  assign op = op_decode(ir_q);

endmodule

// File: rtl/pscan_cell_grp.sv
module pscan_cell_grp (
  input  logic tck,
  input  logic rst,
  input  logic cap,
  input  logic shf,
  input  logic upd,
  input  logic core_out_b,
  input  logic core_oe_b,
  input  logic pad_in_b,
  input  logic si,
  output logic so,
  output logic lat_out,
  output logic lat_oe
);

  // serial order inside a group: si -> input -> output -> control -> so
  logic in_c, out_c, ctl_c;

  always_ff @(posedge tck) begin
    if (rst) begin
      in_c    <= 1'b0;
      out_c   <= 1'b0;
      ctl_c   <= 1'b0;
      lat_out <= 1'b0;
      lat_oe  <= 1'b0;
    end else begin
      if (cap) begin
        in_c  <= pad_in_b;
        out_c <= core_out_b;
        ctl_c <= core_oe_b;
      end else if (shf) begin
        in_c  <= si;
        out_c <= in_c;
        ctl_c <= out_c;
      end
      if (upd) begin
        lat_out <= out_c;
        lat_oe  <= ctl_c;
      end
    end
  end

  assign so = ctl_c;

endmodule

// File: rtl/pad_scan_ctrl.sv
module pad_scan_ctrl
  import pscan_pkg::*;
#(
  parameter int NPADS = 32
) (
  input  logic             tck,
  input  logic             trst,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_oe,
  input  logic             sys_rst,
  input  logic             scan_sel,
  input  logic [NPADS-1:0] core_out,
  input  logic [NPADS-1:0] core_oe,
  output logic [NPADS-1:0] core_in,
  input  logic [NPADS-1:0] pad_in,
  output logic [NPADS-1:0] pad_out,
  output logic [NPADS-1:0] pad_oe
);

  logic            en_q;
  logic            tap_rst;
  tap_st_e         st;
  scan_op_e        op;
  logic [IR_W-1:0] ir_sr;
  logic            byp_q;
  logic            bsr_sel;
  logic            extest;
  logic            g_cap, g_shf, g_upd;
  logic [NPADS:0]  link;
  logic [NPADS-1:0] upd_out, upd_oe;

  // scan enable captured only during chip reset
  always_ff @(posedge tck) begin
    if (sys_rst) en_q <= scan_sel;
  end

  assign tap_rst = trst | ~en_q;

  pscan_tap_fsm u_fsm (
    .tck (tck),
    .rst (tap_rst),
    .tms (tms),
    .st  (st)
  );

  pscan_ir #(.W(IR_W)) u_ir (
    .tck   (tck),
    .rst   (tap_rst),
    .st    (st),
    .tdi   (tdi),
    .ir_sr (ir_sr),
    .op    (op)
  );

  assign bsr_sel = (op != OP_BYPASS);
  assign extest  = (op == OP_EXTEST);
  assign g_cap   = bsr_sel && (st == TS_CAP_DR);
  assign g_shf   = bsr_sel && (st == TS_SH_DR);
  assign g_upd   = extest  && (st == TS_UPD_DR);

  always_ff @(posedge tck) begin
    if (tap_rst)               byp_q <= 1'b0;
    else if (st == TS_CAP_DR)  byp_q <= 1'b0;
    else if (st == TS_SH_DR)   byp_q <= tdi;
  end

  assign link[NPADS] = tdi;

  for (genvar g = 0; g < NPADS; g++) begin : g_pad
    pscan_cell_grp u_grp (
      .tck        (tck),
      .rst        (tap_rst),
      .cap        (g_cap),
      .shf        (g_shf),
      .upd        (g_upd),
      .core_out_b (core_out[g]),
      .core_oe_b  (core_oe[g]),
      .pad_in_b   (pad_in[g]),
      .si         (link[g+1]),
      .so         (link[g]),
      .lat_out    (upd_out[g]),
      .lat_oe     (upd_oe[g])
    );
  end

  always_comb begin
    if (extest) begin
      pad_out = upd_out;
      pad_oe  = upd_oe;
    end else begin
      pad_out = core_out;
      pad_oe  = core_oe;
    end
  end

  assign core_in = pad_in;

  // serial output retimed to the falling edge
  always_ff @(negedge tck) begin
    if (tap_rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      case (st)
        TS_SH_IR: tdo <= ir_sr[0];
        TS_SH_DR: tdo <= bsr_sel ? link[0] : byp_q;
        default:  tdo <= 1'b0;
      endcase
      tdo_oe <= (st == TS_SH_IR) || (st == TS_SH_DR);
    end
  end

endmodule

// File: rtl/pscan_chk.sv
module pscan_chk
  import pscan_pkg::*;
#(
  parameter int NPADS = 32
) (
  input logic             tck,
  input logic             trst,
  input logic             sys_rst,
  input logic             scan_sel,
  input logic             en_q,
  input tap_st_e          st,
  input scan_op_e         op,
  input logic [IR_W-1:0]  ir_sr,
  input logic             tdo_oe,
  input logic [NPADS-1:0] upd_out,
  input logic [NPADS-1:0] upd_oe,
  input logic [NPADS-1:0] core_out,
  input logic [NPADS-1:0] core_oe,
  input logic [NPADS-1:0] pad_out,
  input logic [NPADS-1:0] pad_oe
);

  p_tlr_bypass_r2: assert property (@(posedge tck) disable iff (trst || sys_rst)
    (st == TS_RESET) |=> (op == OP_BYPASS));

  p_capir_r2: assert property (@(posedge tck) disable iff (trst || sys_rst)
    (st == TS_CAP_IR) |=> (ir_sr == IR_W'(1)));

  p_latch_hold_r6: assert property (@(posedge tck) disable iff (trst || sys_rst)
    (en_q && !(st == TS_UPD_DR && op == OP_EXTEST)) |=> ($stable(upd_out) && $stable(upd_oe)));

  p_pass_r7: assert property (@(posedge tck) disable iff (trst || sys_rst)
    (op != OP_EXTEST) |-> (pad_out == core_out && pad_oe == core_oe));

  p_oe_shift_r8: assert property (@(posedge tck) disable iff (trst || sys_rst)
    tdo_oe |-> (st == TS_SH_DR || st == TS_SH_IR));

  p_disabled_r9: assert property (@(posedge tck) disable iff (sys_rst)
    !en_q |=> (st == TS_RESET));

  p_sel_ignored_r9: assert property (@(posedge tck) disable iff (sys_rst)
    !$stable(scan_sel) |=> $stable(en_q));

endmodule

bind pad_scan_ctrl pscan_chk #(.NPADS(NPADS)) u_chk (
  .tck      (tck),
  .trst     (trst),
  .sys_rst  (sys_rst),
  .scan_sel (scan_sel),
  .en_q     (en_q),
  .st       (st),
  .op       (op),
  .ir_sr    (ir_sr),
  .tdo_oe   (tdo_oe),
  .upd_out  (upd_out),
  .upd_oe   (upd_oe),
  .core_out (core_out),
  .core_oe  (core_oe),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe)
);

// File: tb/test_pad_scan_ctrl.sv
module test_pad_scan_ctrl;

  localparam int TCK_PERIOD = 20;
  localparam int NP         = 32;
  localparam int CHAIN      = 3 * NP;

  logic          tck = 1'b0;
  logic          trst, tms, tdi, sys_rst, scan_sel;
  logic [NP-1:0] c_out, c_oe, p_in;
  logic          tdo, tdo_oe;
  logic [NP-1:0] core_in, pad_out, pad_oe;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    logic  v;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  pad_scan_ctrl #(.NPADS(NP)) i_pad_scan_ctrl (
    .tck(tck), .trst(trst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .sys_rst(sys_rst), .scan_sel(scan_sel),
    .core_out(c_out), .core_oe(c_oe), .core_in(core_in),
    .pad_in(p_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #(TCK_PERIOD/2) tck = ~tck;

  task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] expv);
    n_vec++;
    if (ok !== 1'b1) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // monitor: one expected TDO bit per falling edge with the output enabled
  initial forever begin
    @(negedge tck);
    #4;
    if (tdo_oe === 1'b1) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 tdo_oe high with nothing expected", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(tdo === e.v, e.tag, tdo, e.v);
      end
    end
  end

  initial begin
    #(TCK_PERIOD * 100000);
    chk(1'b0, "R1 watchdog expired", 0, 1);
    summary();
  end

  task automatic step(input logic m, input logic d);
    @(negedge tck); #2;
    tms = m; tdi = d;
    @(posedge tck); #1;
  endtask

  task automatic shift_bit(input logic m, input logic d);
    logic pre;
    @(negedge tck); #2;
    tms = m; tdi = d;
    pre = tdo;
    @(posedge tck); #1;
    chk(tdo === pre, "R8 tdo moved on rising edge", tdo, pre);
  endtask

  task automatic pads_are(input logic [NP-1:0] xo, input logic [NP-1:0] xe, input string tag);
    chk(pad_out === xo && pad_oe === xe && core_in === p_in, tag,
        {pad_out, pad_oe, core_in}, {xo, xe, p_in});
  endtask

  task automatic queue_done();
    @(negedge tck); #5;
    chk(exp_q.size() == 0, "R8 expected bits left unshifted", exp_q.size(), 0);
  endtask

  // from Run-Test/Idle back to Run-Test/Idle
  task automatic shift_ir(input logic [1:0] code, input string tag);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    exp_q.push_back('{1'b1, tag});
    exp_q.push_back('{1'b0, tag});
    shift_bit(0, code[0]);
    shift_bit(1, code[1]);
    step(1, 0); step(0, 0);
    queue_done();
  endtask

  task automatic shift_dr(input logic [CHAIN-1:0] pat, input logic [CHAIN-1:0] ex, input int n,
                          input string tag, input logic [NP-1:0] ho, input logic [NP-1:0] he,
                          input string htag);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) exp_q.push_back('{ex[i], tag});
    for (int i = 0; i < n; i++) shift_bit(i == n - 1, pat[i]);
    pads_are(ho, he, htag);
    step(1, 0); step(0, 0);
    queue_done();
  endtask

  function automatic logic [CHAIN-1:0] cap_exp();
    logic [CHAIN-1:0] e;
    for (int p = 0; p < NP; p++) begin
      e[3*p]   = c_oe[p];
      e[3*p+1] = c_out[p];
      e[3*p+2] = p_in[p];
    end
    return e;
  endfunction

  function automatic logic [CHAIN-1:0] mk_pat(input logic [NP-1:0] xo, input logic [NP-1:0] xe);
    logic [CHAIN-1:0] r;
    for (int p = 0; p < NP; p++) begin
      r[3*p]   = xe[p];
      r[3*p+1] = xo[p];
      r[3*p+2] = xo[p] ^ xe[p];
    end
    return r;
  endfunction

  localparam logic [8:0] BP = 9'b1_0110_1001;
  localparam logic [NP-1:0] X1 = 32'hDEAD_1F2E, Y1 = 32'h0F0F_A5A5;
  localparam logic [NP-1:0] X2 = 32'h1357_9BDF, Y2 = 32'hFFFF_0001;

  initial begin
    trst = 1; sys_rst = 1; scan_sel = 1; tms = 0; tdi = 0;
    c_out = 32'hA5C3_0F96; c_oe = 32'h3C5A_9E01; p_in = 32'h1234_FEDC;
    repeat (3) @(posedge tck);
    #1; trst = 0; sys_rst = 0;
    @(negedge tck); #4;
    chk(tdo_oe === 1'b0, "R8 tdo_oe low after reset", tdo_oe, 0);
    pads_are(c_out, c_oe, "R7 pass-through after reset");
    step(0, 0);

    // SAMPLE
    shift_ir(2'b01, "R2 capture-IR pattern 1,0");
    shift_dr(96'h9E37_79B9_7F4A_7C15_F39C_C060, cap_exp(), CHAIN, "R5 SAMPLE capture",
             c_out, c_oe, "R7 pads pass during SAMPLE shift");
    pads_are(c_out, c_oe, "R7 pads pass after SAMPLE update");

    // EXTEST: latches still at reset value despite the SAMPLE update
    shift_ir(2'b00, "R2 capture-IR pattern before EXTEST");
    pads_are('0, '0, "R6 SAMPLE update left latches clear");
    c_out = 32'h0123_4567; c_oe = 32'h89AB_CDEF; p_in = 32'hFEDC_BA98;
    shift_dr(mk_pat(X1, Y1), cap_exp(), CHAIN, "R4 chain order on EXTEST capture",
             '0, '0, "R7 pads steady while shifting");
    pads_are(X1, Y1, "R6 EXTEST update drives pads");
    p_in = 32'h5555_AAAA;
    shift_dr(mk_pat(X2, Y2), cap_exp(), CHAIN, "R5 EXTEST capture of core and pad",
             X1, Y1, "R7 pads hold old latches while shifting");
    pads_are(X2, Y2, "R6 second EXTEST update");

    // BYPASS and the spare code
    shift_ir(2'b11, "R2 capture-IR pattern before BYPASS");
    pads_are(c_out, c_oe, "R7 pads pass under BYPASS");
    shift_dr({87'b0, BP}, {87'b0, BP[7:0], 1'b0}, 9, "R3 bypass one-shift delay",
             c_out, c_oe, "R7 pads pass in bypass shift");
    shift_ir(2'b10, "R2 capture-IR pattern before code 10");
    pads_are(c_out, c_oe, "R2 code 10 passes pads");
    shift_dr({87'b0, ~BP}, {87'b0, ~BP[7:0], 1'b0}, 9, "R2 code 10 acts as bypass",
             c_out, c_oe, "R2 code 10 pads pass");

    // TMS reset path
    shift_ir(2'b00, "R2 capture-IR pattern re-entering EXTEST");
    pads_are(X2, Y2, "R6 latches kept across instructions");
    repeat (5) step(1, 0);
    pads_are(c_out, c_oe, "R1 five TMS-high cycles drop EXTEST");
    step(0, 0);
    shift_dr({87'b0, BP}, {87'b0, BP[7:0], 1'b0}, 9, "R1 IR back to bypass after TMS reset",
             c_out, c_oe, "R1 pads pass after TMS reset");

    // trst path
    shift_ir(2'b00, "R2 capture-IR pattern before trst");
    pads_are(X2, Y2, "R6 latches kept after TMS reset");
    @(negedge tck); #2; trst = 1;
    @(posedge tck); #1; trst = 0;
    pads_are(c_out, c_oe, "R1 trst returns to bypass");
    step(0, 0);
    shift_ir(2'b00, "R2 capture-IR pattern after trst");
    pads_are('0, '0, "R6 trst cleared latches");

    // select captured low: TAP frozen
    @(negedge tck); #2; sys_rst = 1; scan_sel = 0;
    @(posedge tck); @(posedge tck); #1; sys_rst = 0; scan_sel = 1;
    pads_are(c_out, c_oe, "R9 disabled scan passes pads");
    step(0, 0); step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    step(0, 0); step(0, 1);
    @(negedge tck); #4;
    chk(tdo_oe === 1'b0, "R9 tdo_oe stays low while disabled", tdo_oe, 0);
    step(1, 0); step(1, 0); step(0, 0);
    pads_are(c_out, c_oe, "R9 late select rise ignored");

    // select captured high, then dropped: still enabled
    @(negedge tck); #2; sys_rst = 1; scan_sel = 1;
    @(posedge tck); @(posedge tck); #1; sys_rst = 0; scan_sel = 0;
    step(0, 0);
    shift_ir(2'b01, "R9 enabled after select dropped");
    shift_dr(96'h0, cap_exp(), CHAIN, "R9 SAMPLE works after select dropped",
             c_out, c_oe, "R9 pads pass in SAMPLE");

    summary();
  end

endmodule